// File: doc/BRIEF.md
# Bit-Length SPI Master

This block is a synchronous SPI master that shifts any number of bits, one or more, per request over a serial clock, a data-out line, a data-in line and a single chip select. A request gives a bit count and three flags: one opens the chip-select window before the first bit, one closes it after the last bit, and one says whether transmit bytes will be supplied. Transmit bytes arrive on a byte-wide valid/ready stream and leave most-significant bit first. A fresh byte is taken every eighth bit. Receive bits are packed most-significant bit first into bytes, which are returned on a second valid/ready stream. A short final byte is left-justified.

Clock polarity, clock phase, chip-select polarity, the half-period length in system clocks, and separate transmit and receive disables come from static configuration inputs. These must stay constant while the engine is busy. The serial clock stops at a steady level whenever the engine is waiting for a transmit byte or for room to hand back a receive byte. When the close flag is clear, a sequence of requests can keep the chip select asserted across all of them.

Top module: `bitspi_master`

## Requirements
- R1: Transmit data leaves on `mosi` most-significant bit first. A new byte is taken from the transmit stream before bit 0 and before every eighth bit after it (bit index 8k).
- R2: Received bits are packed most-significant bit first. A byte is offered on `rx_data` after its eighth bit or after the last bit of the request. For a short final byte of m bits, the bits occupy [7:8-m] and the low bits are zero. An offered byte and its valid flag hold until `rx_ready` is high.
- R3: When a request has `req_has_tx` low, no transmit bytes are taken and every bit driven on `mosi` is 0.
- R4: With `req_begin` set, chip select is driven inactive with the logical clock at its idle level for one half-period. It is then driven active for one further half-period before the first bit. With `req_begin` clear, chip select keeps its current level.
- R5: With `req_end` set, chip select returns inactive once the last receive byte has been accepted. With `req_end` clear, it stays active after the request completes. Chip select is active at every sampling edge.
- R6: The logical clock idles low. With `cfg_cpha`=0, `mosi` changes while the logical clock is low and `miso` is sampled on its rising edge. With `cfg_cpha`=1, `mosi` changes as the logical clock rises and `miso` is sampled on its falling edge. Exactly one sampling edge occurs per requested bit.
- R7: `sclk` equals the logical clock XOR `cfg_cpol`. `cs_o` equals the active state when `cfg_cs_high`=1, and its inverse when `cfg_cs_high`=0.
- R8: With `cfg_tx_off`=1, `mosi` keeps its previous value for the whole request. With `cfg_rx_off`=1, zeros are shifted in instead of `miso`.
- R9: A request is refused (`req_ready` low, nothing starts) while both `cfg_tx_off` and `cfg_rx_off` are 1, or while `req_bits` is 0.
- R10: Each half of a bit lasts `cfg_half_div`+1 system clocks. Two sampling edges within one byte are 2·(`cfg_half_div`+1) clocks apart.
- R11: `busy` rises on the cycle after a request is accepted. It stays high until the last receive byte has been accepted and any chip-select release is done. Requests are accepted only while `busy` is low.
- R12: While the engine waits for a transmit byte or for the receive byte slot to empty, `sclk` holds its level, and no bit is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_cpol | input | 1 | Clock polarity: inverts `sclk` |
| cfg_cpha | input | 1 | Clock phase: selects the sampling edge |
| cfg_cs_high | input | 1 | 1 makes chip select active-high |
| cfg_tx_off | input | 1 | Freeze `mosi` during transfers |
| cfg_rx_off | input | 1 | Shift in zeros instead of `miso` |
| cfg_half_div | input | DIV_W | Half-period length minus one, in system clocks |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_bits | input | LEN_W | Number of bits to move (must be nonzero) |
| req_begin | input | 1 | Assert chip select before the first bit |
| req_end | input | 1 | Release chip select after the last bit |
| req_has_tx | input | 1 | Transmit bytes will be supplied |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Engine takes a transmit byte |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Receive byte offered |
| rx_ready | input | 1 | Receive byte accepted |
| rx_data | output | 8 | Receive byte |
| busy | output | 1 | Request in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_o | output | 1 | Chip select |
| miso | input | 1 | Serial data in |

## Verification
The bench sweeps every bit count from 1 to 17 under all four clock modes and two half-period settings. This covers counts of 1, 7, 8, 9, 16 and 17, where an off-by-one in byte boundaries would take a transmit byte too early, drop a bit, or return a short byte right-justified instead of left-justified. A slave model on the pins records `mosi` and supplies `miso` at each sampling edge. A wrong phase choice would therefore show up as shifted data and a wrong edge count. Transmit gaps and receive backpressure check that a stall freezes the clock rather than skipping or repeating a bit. Chained requests with the close flag clear check that chip select is not dropped between requests and that a repeated open flag re-pulses it. The disable flags and the refused configurations are checked at the pins.

// File: rtl/bitspi_pkg.sv
package bitspi_pkg;
  localparam int BYTE_W = 8;
  localparam int POS_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CSPRE,
    ST_CSSET,
    ST_LOAD,
    ST_PHA,
    ST_PHB,
    ST_PUSH,
    ST_FIN
  } bitspi_state_e;
endpackage

// File: rtl/bitspi_halftimer.sv
module bitspi_halftimer #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] limit,
  output logic             expired
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == limit);

  always_comb begin
    if (restart || expired) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bitspi_rxslot.sv
module bitspi_rxslot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         slot_free,
  output logic         rx_valid,
  input  logic         rx_ready,
  output logic [W-1:0] rx_data
);
  logic         vld_q, vld_d;
  logic [W-1:0] dat_q;

  assign slot_free = !vld_q;
  assign rx_valid  = vld_q;
  assign rx_data   = dat_q;

  always_comb begin
    vld_d = vld_q;
    if (push)                 vld_d = 1'b1;
    else if (vld_q && rx_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (push) dat_q <= push_data;
    end
  end
endmodule

// File: rtl/bitspi_master.sv
module bitspi_master
  import bitspi_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_cs_high,
  input  logic             cfg_tx_off,
  input  logic             cfg_rx_off,
  input  logic [DIV_W-1:0] cfg_half_div,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LEN_W-1:0] req_bits,
  input  logic             req_begin,
  input  logic             req_end,
  input  logic             req_has_tx,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic             busy,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_o,
  input  logic             miso
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BYTE_W - 1);

  bitspi_state_e     state_q, state_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic [BYTE_W-1:0] txsh_q, txsh_d, rxsh_q, rxsh_d;
  logic              lclk_q, lclk_d, csact_q, csact_d, mosi_q, mosi_d;
  logic              htx_q, htx_d, end_q, end_d;
  logic              expired, slot_free, push;
  logic [BYTE_W-1:0] push_data;
  logic              cfg_ok;

  assign cfg_ok    = !(cfg_tx_off && cfg_rx_off);
  assign req_ready = (state_q == ST_IDLE) && cfg_ok && (req_bits != '0);
  assign tx_ready  = (state_q == ST_LOAD) && htx_q;
  assign busy      = (state_q != ST_IDLE);
  assign sclk      = lclk_q ^ cfg_cpol;
  assign cs_o      = cfg_cs_high ? csact_q : ~csact_q;
  assign mosi      = mosi_q;
  assign push_data = rxsh_q << (LAST_POS - pos_q);

  bitspi_halftimer #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_d != state_q),
    .limit   (cfg_half_div),
    .expired (expired)
  );

  bitspi_rxslot #(.W(BYTE_W)) u_rxslot (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .slot_free (slot_free),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .rx_data   (rx_data)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    pos_d   = pos_q;
    txsh_d  = txsh_q;
    rxsh_d  = rxsh_q;
    lclk_d  = lclk_q;
    csact_d = csact_q;
    mosi_d  = mosi_q;
    htx_d   = htx_q;
    end_d   = end_q;
    push    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && req_ready) begin
          left_d = req_bits;
          htx_d  = req_has_tx;
          end_d  = req_end;
          lclk_d = 1'b0;
          if (req_begin) begin
            csact_d = 1'b0;
            state_d = ST_CSPRE;
          end else begin
            state_d = ST_LOAD;
          end
        end
      end
      ST_CSPRE: begin
        if (expired) begin
          csact_d = 1'b1;
          state_d = ST_CSSET;
        end
      end
      ST_CSSET: begin
        if (expired) state_d = ST_LOAD;
      end
      ST_LOAD: begin
        if (!htx_q || tx_valid) begin
          txsh_d  = htx_q ? tx_data : '0;
          rxsh_d  = '0;
          pos_d   = '0;
          lclk_d  = cfg_cpha;
          if (!cfg_tx_off) mosi_d = htx_q & tx_data[BYTE_W-1];
          state_d = ST_PHA;
        end
      end
      ST_PHA: begin
        if (expired) begin
          lclk_d  = ~cfg_cpha;
          rxsh_d  = {rxsh_q[BYTE_W-2:0], ~cfg_rx_off & miso};
          txsh_d  = {txsh_q[BYTE_W-2:0], 1'b0};
          state_d = ST_PHB;
        end
      end
      ST_PHB: begin
        if (expired) begin
          left_d = left_q - 1'b1;
          if (left_q == LEN_W'(1) || pos_q == LAST_POS) begin
            state_d = ST_PUSH;
          end else begin
            pos_d   = pos_q + 1'b1;
            lclk_d  = cfg_cpha;
            if (!cfg_tx_off) mosi_d = txsh_q[BYTE_W-1];
            state_d = ST_PHA;
          end
        end
      end
      ST_PUSH: begin
        if (slot_free) begin
          push = 1'b1;
          if (left_q == '0) begin
            lclk_d  = 1'b0;
            state_d = ST_FIN;
          end else begin
            state_d = ST_LOAD;
          end
        end
      end
      ST_FIN: begin
        if (expired && slot_free) begin
          if (end_q) csact_d = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      pos_q   <= '0;
      txsh_q  <= '0;
      rxsh_q  <= '0;
      lclk_q  <= 1'b0;
      csact_q <= 1'b0;
      mosi_q  <= 1'b0;
      htx_q   <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      pos_q   <= pos_d;
      txsh_q  <= txsh_d;
      rxsh_q  <= rxsh_d;
      lclk_q  <= lclk_d;
      csact_q <= csact_d;
      mosi_q  <= mosi_d;
      htx_q   <= htx_d;
      end_q   <= end_d;
    end
  end
endmodule

// File: rtl/bitspi_master_chk.sv
module bitspi_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_cpol,
  input logic       cfg_tx_off,
  input logic       cfg_rx_off,
  input logic       req_valid,
  input logic       req_ready,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       busy,
  input logic       sclk,
  input logic       mosi
);
  assert_reject_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tx_off && cfg_rx_off) |-> !req_ready);

  assert_accept_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> !busy);

  assert_rxpend_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> busy);

  assert_rx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_idle_sclk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cfg_cpol));

  assert_txoff_mosi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_tx_off) |=> $stable(mosi));

  assert_tx_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> $stable(sclk));
endmodule

bind bitspi_master bitspi_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_cpol   (cfg_cpol),
  .cfg_tx_off (cfg_tx_off),
  .cfg_rx_off (cfg_rx_off),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_data    (rx_data),
  .busy       (busy),
  .sclk       (sclk),
  .mosi       (mosi)
);

// File: tb/bitspi_master_bench.sv
module bitspi_master_bench;
  localparam int LEN_W = 8;
  localparam int DIV_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_cs_high = 1'b0;
  logic cfg_tx_off = 1'b0, cfg_rx_off = 1'b0;
  logic [DIV_W-1:0] cfg_half_div = '0;
  logic req_valid = 1'b0, req_begin = 1'b0, req_end = 1'b0, req_has_tx = 1'b0;
  logic [LEN_W-1:0] req_bits = '0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic rx_ready = 1'b1;
  logic miso = 1'b0;
  logic req_ready, tx_ready, rx_valid, busy, sclk, mosi, cs_o;
  logic [7:0] rx_data;

  int total = 0, fails = 0;
  int nedge = 0, t0 = 0, t1 = 0, cyc = 0, cs_off = 0, cs_bad = 0, seed = 0;
  logic cap [0:63];
  logic lclk_prev = 1'b0;

  always #4 clk = ~clk;

  bitspi_master #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_bitspi_master (
    .clk(clk), .rst_n(rst_n),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_cs_high(cfg_cs_high),
    .cfg_tx_off(cfg_tx_off), .cfg_rx_off(cfg_rx_off), .cfg_half_div(cfg_half_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_bits(req_bits),
    .req_begin(req_begin), .req_end(req_end), .req_has_tx(req_has_tx),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .busy(busy), .sclk(sclk), .mosi(mosi), .cs_o(cs_o), .miso(miso)
  );

  function automatic logic mbit(input int s, input int i);
    return ((i * 5 + s * 3 + i / 3) % 7) < 3;
  endfunction

  function automatic logic [7:0] tbyte(input int s, input int k);
    return 8'(s * 37 + k * 11 + 5);
  endfunction

  function automatic logic [7:0] exp_rx(input int s, input int n, input int k, input logic off);
    logic [7:0] v;
    v = '0;
    for (int j = 0; j < 8; j++)
      if (8 * k + j < n && !off) v[7 - j] = mbit(s, 8 * k + j);
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pin-level slave model: sees each sampling edge one half clock later
  always @(negedge clk) begin
    logic lc;
    lc = sclk ^ cfg_cpol;
    if (lc != lclk_prev && lc == ~cfg_cpha) begin
      if (nedge < 64) cap[nedge] = mosi;
      if (nedge == 0) t0 = cyc;
      if (nedge == 1) t1 = cyc;
      if (cs_o != cfg_cs_high) cs_bad++;
      nedge++;
      miso = mbit(seed, nedge);
    end
    lclk_prev = lc;
    if (busy && cs_o != cfg_cs_high) cs_off++;
    cyc++;
  end

  task automatic xfer(input int n, input bit bg, input bit en, input bit htx,
                      input int gap, input bit rbp);
    int nbytes;
    logic m0;
    nbytes = (n + 7) / 8;
    @(negedge clk); #2;
    seed++;
    nedge = 0; cs_off = 0; cs_bad = 0; t0 = 0; t1 = 0;
    miso = mbit(seed, 0);
    m0 = mosi;
    req_bits = LEN_W'(n); req_begin = bg; req_end = en; req_has_tx = htx;
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    fork
      begin
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R11 busy after accept", int'(busy), 1);
      end
      begin
        if (htx) for (int k = 0; k < nbytes; k++) begin
          repeat (gap) @(negedge clk);
          tx_data = tbyte(seed, k);
          tx_valid = 1'b1;
          #1;
          while (!tx_ready) begin @(negedge clk); #1; end
          @(negedge clk);
          tx_valid = 1'b0;
        end
      end
      begin
        int got = 0, lc = 0;
        while (got < nbytes) begin
          @(negedge clk);
          lc++;
          rx_ready = !rbp || (lc % 3 != 0);
          #1;
          if (rx_valid && rx_ready) begin
            chk(rx_data == exp_rx(seed, n, got, cfg_rx_off),
                cfg_rx_off ? "R8 rx disabled byte" : "R2 rx byte",
                int'(rx_data), int'(exp_rx(seed, n, got, cfg_rx_off)));
            got++;
          end
        end
        rx_ready = 1'b1;
      end
    join
    while (busy) begin @(negedge clk); #1; end
    chk(nedge == n, "R6 sampling edge count", nedge, n);
    if (gap > 0) chk(nedge == n, "R12 bits with tx stalls", nedge, n);
    for (int i = 0; i < n && i < 64; i++) begin
      logic [7:0] tb;
      logic e;
      tb = tbyte(seed, i / 8);
      if (cfg_tx_off) e = m0;
      else if (htx)   e = tb[7 - (i % 8)];
      else            e = 1'b0;
      chk(cap[i] == e, cfg_tx_off ? "R8 mosi frozen" : (htx ? "R1 mosi bit" : "R3 mosi zero"),
          int'(cap[i]), int'(e));
    end
    chk(cs_bad == 0, "R5 cs active at sampling", cs_bad, 0);
    chk(cs_off == (bg ? int'(cfg_half_div) + 1 : 0), "R4 cs inactive window", cs_off,
        bg ? int'(cfg_half_div) + 1 : 0);
    if (n >= 2) chk(t1 - t0 == 2 * (int'(cfg_half_div) + 1), "R10 bit period", t1 - t0,
                    2 * (int'(cfg_half_div) + 1));
    chk(sclk == cfg_cpol, "R7 sclk idle level", int'(sclk), int'(cfg_cpol));
    chk(cs_o == (en ? ~cfg_cs_high : cfg_cs_high), "R5 cs after request", int'(cs_o),
        int'(en ? ~cfg_cs_high : cfg_cs_high));
  endtask

  task automatic set_cfg(input logic pol, input logic pha, input logic csh, input int div);
    @(negedge clk); #2;
    cfg_cpol = pol; cfg_cpha = pha; cfg_cs_high = csh; cfg_half_div = DIV_W'(div);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(busy == 1'b0 && rx_valid == 1'b0, "R11 reset idle", int'(busy), 0);
    chk(cs_o == 1'b1, "R7 reset cs inactive low-active", int'(cs_o), 1);
    chk(sclk == 1'b0, "R7 reset sclk", int'(sclk), 0);

    // sweep: all modes, two half-periods, bit counts 1..17
    for (int md = 0; md < 4; md++)
      for (int dv = 0; dv < 2; dv++) begin
        set_cfg(md[1], md[0], md[1] ^ md[0], dv * 3);
        for (int n = 1; n <= 17; n++)
          xfer(n, 1'b1, 1'b1, 1'b1, (n % 3 == 0) ? 3 : 0, n[0]);
      end

    set_cfg(1'b0, 1'b0, 1'b0, 1);
    // R3: no transmit data
    xfer(11, 1'b1, 1'b1, 1'b0, 0, 1'b0);
    // R8: transmit disabled
    @(negedge clk); #2; cfg_tx_off = 1'b1;
    xfer(10, 1'b1, 1'b1, 1'b1, 0, 1'b0);
    @(negedge clk); #2; cfg_tx_off = 1'b0;
    xfer(3, 1'b1, 1'b1, 1'b1, 0, 1'b0);
    @(negedge clk); #2; cfg_tx_off = 1'b1;
    xfer(6, 1'b1, 1'b1, 1'b1, 0, 1'b1);
    @(negedge clk); #2; cfg_tx_off = 1'b0; cfg_rx_off = 1'b1;
    xfer(13, 1'b1, 1'b1, 1'b1, 0, 1'b0);
    @(negedge clk); #2; cfg_rx_off = 1'b0;

    // R4/R5: chip select held across requests, then re-opened, then closed
    set_cfg(1'b1, 1'b1, 1'b1, 2);
    xfer(9, 1'b1, 1'b0, 1'b1, 0, 1'b0);
    xfer(9, 1'b1, 1'b0, 1'b1, 2, 1'b1);
    xfer(4, 1'b0, 1'b0, 1'b1, 0, 1'b0);
    xfer(5, 1'b0, 1'b1, 1'b1, 0, 1'b0);

    // R9: refused requests
    begin
      bit seen_rdy, seen_busy;
      seen_rdy = 0; seen_busy = 0;
      @(negedge clk); #2;
      cfg_tx_off = 1'b1; cfg_rx_off = 1'b1; req_bits = 8'd8; req_valid = 1'b1;
      repeat (6) begin
        @(negedge clk); #1;
        if (req_ready) seen_rdy = 1;
        if (busy) seen_busy = 1;
      end
      req_valid = 1'b0;
      chk(!seen_rdy, "R9 both disables refused", int'(seen_rdy), 0);
      chk(!seen_busy, "R9 no start when refused", int'(seen_busy), 0);
      cfg_tx_off = 1'b0; cfg_rx_off = 1'b0; req_bits = '0;
      #1;
      chk(req_ready == 1'b0, "R9 zero bit count refused", int'(req_ready), 0);
      req_bits = 8'd1;
      #1;
      chk(req_ready == 1'b1, "R11 ready when idle", int'(req_ready), 1);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule